// File: doc/BRIEF.md
# Asynchronous SRAM byte-lane controller

This block sits between a synchronous host port and an external asynchronous static RAM of 128K words by 32 bits. The RAM's data word is divided into four 8-bit lanes, and each lane has its own active-low select. The host offers one request at a time through a valid/ready handshake. A request carries a word address, write data, a per-lane byte mask and a write flag. The controller then runs a single write or read cycle on the RAM pins. A read returns its data with a one-cycle valid pulse.

All RAM timing limits are parameters given in whole clock cycles. Each one is the nanosecond figure rounded up. These limits cover address setup, write-enable pulse width, data setup before the write ends, the delay for the RAM to release the bus after write enable falls, write cycle time, and read access time. A short sequencer walks each access through a setup, a strobe and a hold phase. The shared bidirectional data bus appears as separate in, out and drive-enable signals, so an I/O buffer at the chip edge can join them.

The controller turns its own drivers on only once the RAM is certain to be silent. It turns them off before it lets the RAM drive, so the bus never has two drivers at once.

Top module: `sram_lane_ctrl`

## Requirements
- R1: In the cycle after reset is released, all four lane selects, write enable and output enable are high, the data drivers are off, `rsp_valid` is low and `req_ready` is high.
- R2: Mask bit i controls lane select i, and lane i carries data bits 8i+7..8i. During an access the select of every set mask bit is low and the select of every clear mask bit stays high. No select is low while `req_ready` is high.
- R3: A write holds write enable low for at least T_PWE cycles. The selects are low for the whole pulse, and the RAM address stays constant while any select is low.
- R4: The data drivers switch on only after write enable has been low for at least T_HZWE cycles. They are on for at least T_DSU cycles before write enable rises, and they are still on in the cycle in which the write ends (zero hold).
- R5: A read drives output enable low with write enable high and samples the bus after max(T_AA, T_DOE) cycles. `rsp_valid` is a single-cycle pulse, and lanes whose mask bit is clear read back as zero.
- R6: A mask of 4'b0000 asserts no select. A write with this mask leaves memory unchanged, and a read with it still returns a `rsp_valid` pulse with data zero.
- R7: `req_ready` falls in the cycle after acceptance. It stays low for at least T_WC cycles on a write, and on a read until after the `rsp_valid` pulse. A request presented while `req_ready` is low is ignored.
- R8: Output enable and the data drivers are never active in the same cycle. Output enable falls only when the drivers were already off in the previous cycle, and write enable and output enable are never both low.
- R9: A read returns, per lane, the byte of the most recent write to that address whose mask selected that lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 32 | Write data |
| req_mask | input | 4 | Byte-lane mask, bit i = lane i |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | 32 | Read data, unselected lanes zero |
| mem_addr | output | 17 | RAM address |
| mem_cs_n | output | 4 | Per-lane select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dout | output | 32 | Data toward RAM |
| mem_drv_en | output | 1 | Enable for the data drivers toward RAM |
| mem_din | input | 32 | Data from RAM |

## Verification
The hardest situations to reach from the ports are bus turnaround between a read and a write that follow each other closely, and a request that arrives while the controller is busy. The bench therefore interleaves reads and writes back to back from a pseudo-random sequence. A bench RAM model watches for the controller and the RAM driving the bus together, and for drivers that switch on too early relative to write enable. To exercise the busy case, the bench holds a second request on the host port for two cycles in the middle of a write, withdraws it before `req_ready` returns, and then reads the targeted address to show that nothing was written.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } seq_state_t;

  function automatic int cmax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             done
);

  always_comb begin
    if (load)
      cnt_nxt = load_val;
    else if (cnt != '0)
      cnt_nxt = cnt - 1'b1;
    else
      cnt_nxt = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else
      cnt <= cnt_nxt;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
  import sram_lane_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int T_ASU  = 1,
  parameter int T_PWE  = 3,
  parameter int T_DSU  = 2,
  parameter int T_HZWE = 2,
  parameter int T_WC   = 4,
  parameter int T_AA   = 4,
  parameter int T_DOE  = 2,
  parameter int T_TURN = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [LANES-1:0] req_mask,
  input  logic             cur_write,
  input  logic [LANES-1:0] cur_mask,
  output logic             accept,
  output logic             capture,
  output logic             req_ready,
  output logic [LANES-1:0] cs_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             drv_en
);

  // phase lengths in cycles
  localparam int SETC  = cmax(1, T_ASU);
  localparam int STB   = cmax(1, cmax(T_PWE, T_HZWE + T_DSU));
  localparam int RDC   = cmax(1, cmax(T_AA, T_DOE));
  localparam int WHOLD = cmax(1, T_WC - SETC - STB);
  localparam int RHOLD = cmax(1, T_TURN);
  localparam int MAXL  = cmax(cmax(SETC, STB), cmax(RDC, cmax(WHOLD, RHOLD)));
  localparam int CNT_W = $clog2(MAXL + 1);

  localparam logic [CNT_W-1:0] SETC_M1  = CNT_W'(SETC - 1);
  localparam logic [CNT_W-1:0] STB_M1   = CNT_W'(STB - 1);
  localparam logic [CNT_W-1:0] RDC_M1   = CNT_W'(RDC - 1);
  localparam logic [CNT_W-1:0] WHOLD_M1 = CNT_W'(WHOLD - 1);
  localparam logic [CNT_W-1:0] RHOLD_M1 = CNT_W'(RHOLD - 1);
  // drivers come on once the remaining strobe count drops below this
  localparam logic [CNT_W-1:0] DRV_FROM = CNT_W'(STB - T_HZWE);

  seq_state_t       state, nstate;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             done;
  logic [LANES-1:0] mask_sel;

  sram_lane_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .cnt      (cnt),
    .cnt_nxt  (cnt_nxt),
    .done     (done)
  );

  always_comb begin
    nstate   = state;
    load     = 1'b0;
    load_val = '0;
    unique case (state)
      ST_IDLE: if (req_valid) begin
        nstate   = ST_SETUP;
        load     = 1'b1;
        load_val = SETC_M1;
      end
      ST_SETUP: if (done) begin
        nstate   = ST_STROBE;
        load     = 1'b1;
        load_val = cur_write ? STB_M1 : RDC_M1;
      end
      ST_STROBE: if (done) begin
        nstate   = ST_HOLD;
        load     = 1'b1;
        load_val = cur_write ? WHOLD_M1 : RHOLD_M1;
      end
      ST_HOLD: if (done) nstate = ST_IDLE;
      default: nstate = ST_IDLE;
    endcase
  end

  assign accept   = (state == ST_IDLE) && req_valid;
  assign capture  = (state == ST_STROBE) && !cur_write && done;
  assign mask_sel = (state == ST_IDLE) ? req_mask : cur_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      req_ready <= 1'b1;
      cs_n      <= '1;
      we_n      <= 1'b1;
      oe_n      <= 1'b1;
      drv_en    <= 1'b0;
    end else begin
      state     <= nstate;
      req_ready <= (nstate == ST_IDLE);
      cs_n      <= ((nstate == ST_SETUP) || (nstate == ST_STROBE)) ? ~mask_sel : '1;
      we_n      <= !((nstate == ST_STROBE) && cur_write);
      oe_n      <= !((nstate == ST_STROBE) && !cur_write && (state == ST_STROBE || state == ST_SETUP));
      drv_en    <= cur_write && (state != ST_IDLE) &&
                   (((nstate == ST_STROBE) && (cnt_nxt < DRV_FROM)) ||
                    ((state == ST_STROBE) && (nstate == ST_HOLD)));
    end
  end

endmodule

// File: rtl/sram_lane_data.sv
module sram_lane_data #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  parameter int LANES  = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              capture,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  input  logic [DATA_W-1:0] mem_din,
  output logic              cur_write,
  output logic [LANES-1:0]  cur_mask,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  logic [DATA_W-1:0] din_masked;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign din_masked[l*LANE_W +: LANE_W] =
        cur_mask[l] ? mem_din[l*LANE_W +: LANE_W] : '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_write <= 1'b0;
      cur_mask  <= '0;
      cur_addr  <= '0;
      cur_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (accept) begin
        cur_write <= req_write;
        cur_mask  <= req_mask;
        cur_addr  <= req_addr;
        cur_wdata <= req_wdata;
      end
      rsp_valid <= capture;
      if (capture) rsp_data <= din_masked;
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  parameter int T_ASU  = 1,
  parameter int T_PWE  = 3,
  parameter int T_DSU  = 2,
  parameter int T_HZWE = 2,
  parameter int T_WC   = 4,
  parameter int T_AA   = 4,
  parameter int T_DOE  = 2,
  parameter int T_TURN = 1,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_drv_en,
  input  logic [DATA_W-1:0] mem_din
);

  logic             accept, capture, cur_write;
  logic [LANES-1:0] cur_mask;

  sram_lane_seq #(
    .LANES(LANES), .T_ASU(T_ASU), .T_PWE(T_PWE), .T_DSU(T_DSU),
    .T_HZWE(T_HZWE), .T_WC(T_WC), .T_AA(T_AA), .T_DOE(T_DOE), .T_TURN(T_TURN)
  ) seq_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_mask  (req_mask),
    .cur_write (cur_write),
    .cur_mask  (cur_mask),
    .accept    (accept),
    .capture   (capture),
    .req_ready (req_ready),
    .cs_n      (mem_cs_n),
    .we_n      (mem_we_n),
    .oe_n      (mem_oe_n),
    .drv_en    (mem_drv_en)
  );

  sram_lane_data #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W), .LANES(LANES)
  ) data_i (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .capture   (capture),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_mask  (req_mask),
    .mem_din   (mem_din),
    .cur_write (cur_write),
    .cur_mask  (cur_mask),
    .cur_addr  (mem_addr),
    .cur_wdata (mem_dout),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int ADDR_W = 17,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [LANES-1:0]  mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_drv_en
);

  logic rst_q = 1'b0;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    // R1
    if (rst_q) begin
      reset_idle_chk: assert (mem_cs_n == '1 && mem_we_n && mem_oe_n &&
                              !mem_drv_en && !rsp_valid && req_ready)
        else $error("outputs not idle after reset");
    end
  end

  // R2
  cs_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_cs_n != '1) |-> !req_ready);

  // R3
  addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> $stable(mem_addr));

  // R4
  drv_after_we_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_drv_en) |-> !mem_we_n);

  // R5
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R8
  no_contention_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_drv_en && !mem_oe_n));

  // R8
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!mem_we_n && !mem_oe_n));

  // R8
  oe_after_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_oe_n) |-> !$past(mem_drv_en));

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_addr   (mem_addr),
  .mem_cs_n   (mem_cs_n),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_drv_en (mem_drv_en)
);

// File: tb/sram_lane_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_lane_ctrl_tb_top;

  localparam int P_PWE = 3, P_DSU = 2, P_HZWE = 2, P_WC = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_mask = '0;
  logic        req_ready, rsp_valid, mem_we_n, mem_oe_n, mem_drv_en;
  logic [31:0] rsp_data, mem_dout;
  logic [31:0] mem_din = '0;
  logic [16:0] mem_addr;
  logic [3:0]  mem_cs_n;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  sram_lane_ctrl dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dout(mem_dout), .mem_drv_en(mem_drv_en),
    .mem_din(mem_din)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bench RAM and independent reference
  logic [31:0] sram [int];
  logic [31:0] ref_mem [int];
  logic [31:0] exp_q [$];

  function automatic logic [31:0] lane_bits(input logic [3:0] m);
    logic [31:0] r;
    for (int l = 0; l < 4; l++) r[l*8 +: 8] = {8{m[l]}};
    return r;
  endfunction

  function automatic logic [31:0] ref_get(input logic [16:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 32'h0;
  endfunction

  function automatic logic [31:0] sram_get(input logic [16:0] a);
    return sram.exists(int'(a)) ? sram[int'(a)] : 32'h0;
  endfunction

  // RAM model and pin-timing monitor
  logic [3:0]  exp_mask = '0;
  int          cs_low_cnt = 0;
  int          weq = 0, drvq = 0;
  logic [3:0]  act_prev = '0;
  logic        drv_prev = 1'b0;
  logic        cs_prev_low = 1'b0;
  logic [16:0] addr_prev = '0;

  always @(negedge clk) begin
    if (!rst) begin
      logic [3:0]  act;
      logic [31:0] word, rd;
      bit          rdrv;
      act  = ~mem_cs_n & {4{~mem_we_n}};
      word = sram_get(mem_addr);
      // lane select correspondence (R2)
      if (mem_cs_n != 4'hF) begin
        cs_low_cnt++;
        check(mem_cs_n == ~exp_mask, "R2 lane selects", {28'h0, mem_cs_n}, {28'h0, ~exp_mask});
        if (cs_prev_low)
          check(mem_addr == addr_prev, "R3 address stable", {15'h0, mem_addr}, {15'h0, addr_prev});
      end
      cs_prev_low = (mem_cs_n != 4'hF);
      addr_prev   = mem_addr;
      // drivers switch on only after write enable has been low long enough (R4)
      if (mem_drv_en && !drv_prev)
        check(weq >= P_HZWE, "R4 driver on after WE low", weq, P_HZWE);
      // write ends
      for (int l = 0; l < 4; l++) begin
        if (act_prev[l] && !act[l]) begin
          check(mem_drv_en, "R4 data held at write end", {31'h0, mem_drv_en}, 32'h1);
          word[l*8 +: 8] = mem_dout[l*8 +: 8];
        end
      end
      if (act_prev != 4'h0 && act == 4'h0) begin
        sram[int'(mem_addr)] = word;
      end
      if (mem_we_n && weq != 0) begin
        check(weq >= P_PWE, "R3 WE pulse width", weq, P_PWE);
        check(drvq >= P_DSU, "R4 data setup", drvq, P_DSU);
      end
      weq  = mem_we_n ? 0 : weq + 1;
      drvq = (!mem_we_n && mem_drv_en) ? drvq + 1 : 0;
      act_prev = act;
      drv_prev = mem_drv_en;
      // read drive from the RAM model
      rd = 32'h0;
      rdrv = 1'b0;
      for (int l = 0; l < 4; l++) begin
        if (!mem_cs_n[l] && mem_we_n && !mem_oe_n) begin
          rd[l*8 +: 8] = word[l*8 +: 8];
          rdrv = 1'b1;
        end
      end
      if (rdrv && mem_drv_en)
        check(1'b0, "R8 bus contention", 32'h1, 32'h0);
      mem_din = rd;
      // scoreboard monitor (R5, R9)
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 unexpected response", rsp_data, 32'h0);
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          check(rsp_data == e, "R9 read data", rsp_data, e);
        end
      end
    end
  end

  // driver: issues one request and updates the reference
  task automatic send(input bit wr, input logic [16:0] a, input logic [31:0] d, input logic [3:0] m);
    while (!req_ready) @(negedge clk);
    exp_mask   = m;
    cs_low_cnt = 0;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (wr) ref_mem[int'(a)] = (ref_get(a) & ~lane_bits(m)) | (d & lane_bits(m));
    else    exp_q.push_back(ref_get(a) & lane_bits(m));
  endtask

  task automatic wait_idle();
    while (!req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] x;
    int          busy;
    repeat (4) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(mem_cs_n == 4'hF, "R1 selects high", {28'h0, mem_cs_n}, 32'hF);
    check(mem_we_n && mem_oe_n, "R1 WE/OE high", {30'h0, mem_we_n, mem_oe_n}, 32'h3);
    check(!mem_drv_en, "R1 drivers off", {31'h0, mem_drv_en}, 32'h0);
    check(!rsp_valid && req_ready, "R1 handshake idle", {30'h0, rsp_valid, req_ready}, 32'h1);

    // R9 full-word writes at both address ends
    send(1, 17'h00000, 32'hDEADBEEF, 4'hF);
    send(1, 17'h1FFFF, 32'h12345678, 4'hF);
    send(0, 17'h00000, 32'h0, 4'hF);
    send(0, 17'h1FFFF, 32'h0, 4'hF);

    // R2 / R9 masked byte merge
    send(1, 17'h00010, 32'hFFFFFFFF, 4'hF);
    send(1, 17'h00010, 32'h00000000, 4'b0101);
    send(0, 17'h00010, 32'h0, 4'hF);          // expect FF00FF00
    // R5 unselected lanes read zero
    send(0, 17'h00010, 32'h0, 4'b0010);       // expect 0000FF00

    // R6 zero mask: no selects, no effect, read still answers
    wait_idle();
    send(1, 17'h00010, 32'h0, 4'h0);
    wait_idle();
    check(cs_low_cnt == 0, "R6 no select on zero-mask write", cs_low_cnt, 0);
    send(0, 17'h00010, 32'h0, 4'h0);          // expect 0
    wait_idle();
    check(cs_low_cnt == 0, "R6 no select on zero-mask read", cs_low_cnt, 0);
    send(0, 17'h00010, 32'h0, 4'hF);          // still FF00FF00

    // R7 busy time and ignored request during a write
    wait_idle();
    send(1, 17'h00020, 32'hA5A5A5A5, 4'hF);
    busy = 1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00021;
    req_wdata = 32'h5A5A5A5A; req_mask = 4'hF;
    @(negedge clk); busy++;
    @(negedge clk); busy++;
    req_valid = 1'b0;
    while (!req_ready) begin @(negedge clk); busy++; end
    check(busy - 1 >= P_WC, "R7 write busy cycles", busy - 1, P_WC);
    send(0, 17'h00021, 32'h0, 4'hF);          // ignored request: still 0
    busy = 1;
    while (!req_ready) begin @(negedge clk); busy++; end
    check(exp_q.size() == 0, "R7 read ready after response", exp_q.size(), 0);

    // R8 / R9 interleaved traffic for bus turnaround
    x = 32'hACE12345;
    for (int i = 0; i < 24; i++) begin
      x = {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
      send(1, {13'h0, x[3:0]} + 17'h00100, x, x[7:4] | 4'b0001);
      send(0, {13'h0, x[11:8]} + 17'h00100, 32'h0, x[15:12]);
    end
    wait_idle();
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R5 all responses seen", exp_q.size(), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule